// File: doc/BRIEF.md
# Carry-Lookahead Incrementer

This block adds a one-bit enable to an N-bit unsigned operand and returns an (N+1)-bit result. When the enable is high the result is the operand plus one, with the extra top bit holding the carry out. When the enable is low the operand comes through unchanged with a zero top bit. The block is purely combinational and is meant to sit inside a larger datapath, such as a program counter or an address stepper, where a long ripple chain would limit the clock.

There is no chain of half adders. The carry into bit i is the AND of the enable with every operand bit below i. All of these prefix ANDs come from a shared network whose depth grows with log2(N), not with N, and whose nodes each drive only a few gates. A parameter chooses between two networks. One is a doubling prefix tree in which every node feeds at most two gates. The other splits the bits into fixed-size groups, forms one AND term per group, combines the group terms in a small tree, and then merges each group's incoming term with the running AND inside that group.

Top module: `cla_incr`

## Requirements
- R1: With `inc_en` = 1, `inc_sum` equals `inc_src` + 1, taken as an unsigned (N+1)-bit value.
- R2: With `inc_en` = 0, `inc_sum` equals `inc_src` with a single zero bit added above it.
- R3: `inc_sum[N]` is 1 exactly when `inc_en` = 1 and every bit of `inc_src` is 1. In that case `inc_sum[N-1:0]` is all zeros.
- R4: With `inc_en` = 1 and the lowest zero of `inc_src` at bit k, bits 0 to k-1 of the result are 0, bit k is 1, and bits k+1 to N-1 match `inc_src`. This holds because the carry into bit i is the enable ANDed with all operand bits below i.
- R5: The tree network (`STYLE` = 0) and the grouped network (`STYLE` = 1, with `GROUP` bits per group) give identical outputs for identical inputs.
- R6: The grouped network is also correct when `GROUP` does not divide N+1. For example, N = 8 with `GROUP` = 4 leaves the last group partly filled.
- R7: With N = 8, every one of the 512 combinations of operand and enable gives `inc_src` + `inc_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| inc_src | input | N | Unsigned operand |
| inc_en | input | 1 | Adds one when high; passes the operand through when low |
| inc_sum | output | N+1 | Operand plus enable; bit N is the carry out |

## Verification
A wrong node in the prefix network produces a wrong carry into some bit position. That carry flips exactly that sum bit, or clears a bit that should stay set, as soon as the inputs settle. The fault therefore shows at the ports in the same cycle, but only for operands whose run of trailing ones reaches the faulty position. For this reason the bench walks the lowest zero through every bit position and compares the two network styles on the same operands. A stuck node in the top group shows only on the all-ones operand, which the carry-out checks cover directly.

// File: rtl/cla_inc_pkg.sv
package cla_inc_pkg;

   // Highest number of gate inputs any internal node may drive.
   localparam int unsigned FANOUT_LIMIT = 6;

   // Values of the STYLE parameter.
   localparam int unsigned STYLE_TREE  = 0;
   localparam int unsigned STYLE_GROUP = 1;

   // Number of doubling stages needed to cover w positions.
   function automatic int unsigned stage_count(input int unsigned w);
      int unsigned r;
      r = 0;
      while ((32'd1 << r) < w) r = r + 1;
      return r;
   endfunction

endpackage

// File: rtl/cla_prefix_tree.sv
// Inclusive AND prefix: pt_out[i] = pt_in[0] & ... & pt_in[i].
// Every stage doubles the span covered; each node feeds at most two gates.
module cla_prefix_tree #(
   parameter int unsigned W = 65
) (
   input  logic [W-1:0] pt_in,
   output logic [W-1:0] pt_out
);
   localparam int unsigned L = cla_inc_pkg::stage_count(W);

   if (W < 1) begin : g_bad_w
      $error("cla_prefix_tree: W must be at least 1");
   end

   logic [W-1:0] stage [0:L];

   assign stage[0] = pt_in;

   for (genvar lv = 0; lv < L; lv++) begin : g_lvl
      localparam int unsigned D = 1 << lv;
      for (genvar i = 0; i < W; i++) begin : g_bit
         if (i >= D) begin : g_and
            assign stage[lv+1][i] = stage[lv][i] & stage[lv][i-D];
         end else begin : g_pass
            assign stage[lv+1][i] = stage[lv][i];
         end
      end
   end

   assign pt_out = stage[L];

   always_comb begin
      if (!$isunknown(pt_in)) begin
         // R4
         prefix_base_chk: assert (pt_out[0] == pt_in[0]);
         for (int i = 1; i < W; i++) begin
            // R4
            prefix_step_chk: assert (pt_out[i] == (pt_out[i-1] & pt_in[i]));
         end
      end
   end

endmodule

// File: rtl/cla_prefix_group.sv
// Grouped inclusive AND prefix. Each group of G bits forms a local running
// AND. The group terms are combined in a prefix tree, and the term arriving
// from all lower groups is merged into each local AND.
module cla_prefix_group #(
   parameter int unsigned W = 65,
   parameter int unsigned G = 4
) (
   input  logic [W-1:0] pg_in,
   output logic [W-1:0] pg_out
);
   localparam int unsigned NG   = (W + G - 1) / G;
   localparam int unsigned PADW = NG * G;

   if (G < 2 || G > cla_inc_pkg::FANOUT_LIMIT) begin : g_bad_g
      $error("cla_prefix_group: G must lie between 2 and FANOUT_LIMIT");
   end
   if (W < 1) begin : g_bad_w
      $error("cla_prefix_group: W must be at least 1");
   end

   logic [PADW-1:0] padded;
   logic [PADW-1:0] loc;
   logic [NG-1:0]   grp_term;
   logic [NG-1:0]   grp_pfx;
   logic [NG-1:0]   grp_in;

   // Missing bits of the last group are filled with ones.
   if (PADW > W) begin : g_pad
      assign padded = {{(PADW-W){1'b1}}, pg_in};
   end else begin : g_nopad
      assign padded = pg_in;
   end

   for (genvar g = 0; g < NG; g++) begin : g_grp
      for (genvar k = 0; k < G; k++) begin : g_loc
         localparam int unsigned IDX = g * G + k;
         if (k == 0) begin : g_first
            assign loc[IDX] = padded[IDX];
         end else begin : g_next
            assign loc[IDX] = loc[IDX-1] & padded[IDX];
         end
      end
      assign grp_term[g] = loc[g*G + G - 1];
   end

   cla_prefix_tree #(.W(NG)) u_grp_tree (
      .pt_in  (grp_term),
      .pt_out (grp_pfx)
   );

   for (genvar g = 0; g < NG; g++) begin : g_gin
      if (g == 0) begin : g_zero
         assign grp_in[g] = 1'b1;
      end else begin : g_rest
         assign grp_in[g] = grp_pfx[g-1];
      end
   end

   for (genvar i = 0; i < W; i++) begin : g_out
      assign pg_out[i] = grp_in[i / G] & loc[i];
   end

   always_comb begin
      if (!$isunknown(pg_in)) begin
         // R6
         group_total_chk: assert (grp_pfx[NG-1] == pg_out[W-1]);
         // R4
         group_first_chk: assert (pg_out[0] == pg_in[0]);
      end
   end

endmodule

// File: rtl/cla_sum_xor.sv
// Sum stage: each result bit is the operand bit flipped by its carry.
module cla_sum_xor #(
   parameter int unsigned N = 64
) (
   input  logic [N-1:0] sx_src,
   input  logic [N:0]   sx_carry,
   output logic [N:0]   sx_sum
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      assign sx_sum[i] = sx_src[i] ^ sx_carry[i];
   end
   assign sx_sum[N] = sx_carry[N];
endmodule

// File: rtl/cla_incr.sv
module cla_incr #(
   parameter int unsigned N     = 64,
   parameter int unsigned STYLE = 0,
   parameter int unsigned GROUP = 4
) (
   input  logic [N-1:0] inc_src,
   input  logic         inc_en,
   output logic [N:0]   inc_sum
);
   localparam int unsigned W = N + 1;

   if (N < 1) begin : g_bad_n
      $error("cla_incr: N must be at least 1");
   end

   // Position 0 holds the enable; position i+1 holds operand bit i.
   logic [W-1:0] chain_in;
   logic [W-1:0] carry;

   assign chain_in = {inc_src, inc_en};

   if (STYLE == cla_inc_pkg::STYLE_TREE) begin : g_tree
      cla_prefix_tree #(.W(W)) u_pfx (
         .pt_in  (chain_in),
         .pt_out (carry)
      );
   end else if (STYLE == cla_inc_pkg::STYLE_GROUP) begin : g_group
      cla_prefix_group #(.W(W), .G(GROUP)) u_pfx (
         .pg_in  (chain_in),
         .pg_out (carry)
      );
   end else begin : g_bad_style
      $error("cla_incr: STYLE must be 0 or 1");
      assign carry = '0;
   end

   cla_sum_xor #(.N(N)) u_sum (
      .sx_src   (inc_src),
      .sx_carry (carry),
      .sx_sum   (inc_sum)
   );

   always_comb begin
      if (!$isunknown({inc_src, inc_en})) begin
         // R1
         value_chk: assert (inc_sum == ({1'b0, inc_src} + W'(inc_en)));
         // R2
         passthru_chk: assert (inc_en || inc_sum == {1'b0, inc_src});
         // R3
         carry_out_chk: assert (inc_sum[N] == (inc_en && (&inc_src)));
         // R3
         wrap_zero_chk: assert (!inc_sum[N] || inc_sum[N-1:0] == '0);
      end
   end

endmodule

// File: tb/test_cla_incr.sv
module test_cla_incr;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic [63:0] src64 = '0;
   logic        en64  = 1'b0;
   logic [64:0] sum_tree, sum_grp;
   logic [7:0]  src8  = '0;
   logic        en8   = 1'b0;
   logic [8:0]  sum8;

   cla_incr #(.N(64), .STYLE(0), .GROUP(4)) i_cla_incr (
      .inc_src (src64), .inc_en (en64), .inc_sum (sum_tree));
   cla_incr #(.N(64), .STYLE(1), .GROUP(4)) i_cla_incr_grp (
      .inc_src (src64), .inc_en (en64), .inc_sum (sum_grp));
   cla_incr #(.N(8), .STYLE(1), .GROUP(4)) i_cla_incr_n8 (
      .inc_src (src8), .inc_en (en8), .inc_sum (sum8));

   task automatic chk(input string req, input logic [64:0] act, input logic [64:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive64(input logic [63:0] s, input logic e);
      @(negedge clk);
      src64 = s;
      en64  = e;
      #4;
   endtask

   task automatic t_zero();
      drive64('0, 1'b0);
      chk("R2 zero operand", sum_tree, 65'd0);
      drive64('0, 1'b1);
      chk("R1 zero plus one", sum_tree, 65'd1);
   endtask

   task automatic t_passthru();
      for (int j = 0; j < 8; j++) begin
         logic [63:0] v;
         v = {$urandom(), $urandom()};
         if (j == 0) v = '1;
         drive64(v, 1'b0);
         chk("R2 tree passthru", sum_tree, {1'b0, v});
         chk("R2 group passthru", sum_grp, {1'b0, v});
      end
   endtask

   task automatic t_walk();
      for (int k = 0; k < 64; k++) begin
         logic [63:0] v, lowm, exp;
         lowm = (k == 0) ? 64'd0 : ((64'd1 << k) - 64'd1);
         v    = ({$urandom(), $urandom()} & ~(lowm | (64'd1 << k))) | lowm;
         exp  = (v & ~lowm) | (64'd1 << k);
         drive64(v, 1'b1);
         chk("R4 tree carry walk", sum_tree, {1'b0, exp});
         chk("R4 group carry walk", sum_grp, {1'b0, exp});
      end
   endtask

   task automatic t_all_ones();
      drive64('1, 1'b1);
      chk("R3 tree wrap", sum_tree, {1'b1, 64'd0});
      chk("R3 group wrap", sum_grp, {1'b1, 64'd0});
      drive64(64'h7FFF_FFFF_FFFF_FFFF, 1'b1);
      chk("R3 no carry out", sum_tree, {1'b0, 64'h8000_0000_0000_0000});
   endtask

   task automatic t_random();
      for (int j = 0; j < 200; j++) begin
         logic [63:0] v;
         logic        e;
         v = {$urandom(), $urandom()};
         e = 1'($urandom());
         drive64(v, e);
         chk("R1 random value", sum_tree, {1'b0, v} + {64'd0, e});
         chk("R5 styles agree", sum_grp, sum_tree);
      end
   endtask

   task automatic t_narrow();
      for (int e = 0; e < 2; e++) begin
         for (int v = 0; v < 256; v++) begin
            @(negedge clk);
            src8 = 8'(v);
            en8  = 1'(e);
            #4;
            chk("R7 R6 narrow exhaustive", {56'd0, sum8}, 65'(v + e));
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog: run did not finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (2) @(posedge clk);
      t_zero();
      t_passthru();
      t_walk();
      t_all_ones();
      t_random();
      t_narrow();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule